// File: doc/BRIEF.md
# DMA Channel Loop Sequencer

This block sequences the data movement of one DMA channel. Each activation runs one inner loop (a "minor loop") of a programmed byte count. The loop is made of alternating read and write accesses of a programmed size, and each access is held until the memory side acknowledges it. After every minor loop the current iteration count drops by one. When that count runs out, the block reloads it from the beginning count, sets a done flag and, when enabled, raises its interrupt. An optional idle window of 4 or 8 cycles after every access limits the channel's share of the bus.

An activation comes from a software start strobe, from a link trigger sent by another channel, or from a hardware request while the request enable is set. When a minor loop finishes, the block can trigger another channel through its link output. It does this after every minor loop or only when the iteration count runs out. In continuous mode, a per-minor link that targets this same channel restarts the loop at once, without leaving the busy state. A bad configuration sets an error flag and blocks the loop. Address arithmetic and descriptor fetch belong to neighbouring logic.

Top module: `dma_loop_seq`

## Requirements
- R1: An activation is a `sw_start` pulse, a `link_in` pulse, or `hw_req` high while `req_en` is 1. It is accepted only when the block is idle and `cfg_err` is 0. It runs one minor loop of `cfg_nbytes / size` accesses. Each read is followed by a write, starting with a read. `rd_req` or `wr_req` stays high until a cycle with `acc_done` high.
- R2: The access size is 1, 2 or 4 bytes for `cfg_size` 0, 1 or 2.
- R3: `citer_out` decreases by one after each minor loop. When it would reach zero it is reloaded from `cfg_biter` instead, and `done` is set.
- R4: `cfg_link_mode` selects the link behaviour:
  - 1 pulses `link_out` for one cycle after every minor loop.
  - 2 pulses it only after the minor loop that runs the count out.
  - 0 never pulses it.
  - `link_ch_out` carries `cfg_link_ch`.
- R5: `cfg_bwc` sets the idle cycles inserted after each completed access: 4 for code 2, 8 for code 3, none for codes 0 and 1.
- R6: With `cfg_int_major` set, `irq` rises when the count runs out.
- R7: With `cfg_int_half` set, `irq` rises after the minor loop that leaves `citer_out` equal to `cfg_biter / 2` (rounded down), when that value is not zero.
- R8: With `cfg_auto_stop` set, `req_en` clears when the count runs out. A held `hw_req` then starts no further loop.
- R9: An activation sets `cfg_err` and makes no access in any of these cases:
  - `cfg_nbytes` is 0.
  - `cfg_nbytes` is not a multiple of the size.
  - `cfg_size` is 3.
  - the current count is 0.
  - at the start of a major loop, the current count differs from `cfg_biter`.
  While `cfg_err` is set, activations are ignored.
- R10: With `cfg_cont_link` set, link mode 1 and `cfg_link_ch` equal to the channel's own number, each minor loop that does not run the count out goes straight into the next one, with no `link_out` pulse. A single start therefore runs the whole major loop.
- R11: `rem_bytes` equals `citer_out` multiplied by `cfg_nbytes`.
- R12: A `cfg_load` pulse loads the current count from `cfg_citer` and clears `done`, `irq` and `cfg_err`. A `req_en_set` pulse sets `req_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hw_req | input | 1 | Hardware service request (level) |
| req_en_set | input | 1 | Pulse: enable hardware requests |
| sw_start | input | 1 | Pulse: software activation |
| link_in | input | 1 | Pulse: link trigger from another channel |
| cfg_load | input | 1 | Pulse: load current count, clear flags |
| cfg_citer | input | IT_W | Current count value to load |
| cfg_biter | input | IT_W | Beginning count |
| cfg_nbytes | input | NB_W | Bytes per minor loop |
| cfg_size | input | 2 | Access size code |
| cfg_bwc | input | 2 | Stall code |
| cfg_link_mode | input | 2 | Link mode 0/1/2 |
| cfg_link_ch | input | CH_W | Linked channel number |
| cfg_int_major | input | 1 | Interrupt on count run-out |
| cfg_int_half | input | 1 | Interrupt at half count |
| cfg_auto_stop | input | 1 | Clear request enable at run-out |
| cfg_cont_link | input | 1 | Continuous self-link mode |
| acc_done | input | 1 | Access acknowledge |
| rd_req | output | 1 | Read access request |
| wr_req | output | 1 | Write access request |
| busy | output | 1 | Minor loop in progress |
| link_out | output | 1 | Link trigger pulse |
| link_ch_out | output | CH_W | Channel targeted by the link |
| done | output | 1 | Major loop finished |
| cfg_err | output | 1 | Configuration error |
| irq | output | 1 | Channel interrupt |
| req_en | output | 1 | Hardware request enable |
| citer_out | output | IT_W | Current iteration count |
| rem_bytes | output | NB_W+IT_W | Remaining bytes |

## Verification
A wrong byte counter shows at the ports as a changed number of acknowledged read/write pairs before `busy` drops, within the same minor loop. A wrong stall counter shows as a changed count of busy cycles with no access pending. A wrong iteration count shows as a wrong `citer_out` or `rem_bytes` right after the affected minor loop. It also shows as `done`, `irq` or a link pulse arriving one loop early or late. A wrong error decision shows at once, either as accesses under a bad configuration or as a valid one that never starts.

// File: rtl/dma_loop_seq.sv
module dma_loop_seq #(
  parameter int NB_W  = 16,
  parameter int IT_W  = 9,
  parameter int CH_W  = 4,
  parameter int CH_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_req,
  input  logic              req_en_set,
  input  logic              sw_start,
  input  logic              link_in,
  input  logic              cfg_load,
  input  logic [IT_W-1:0]   cfg_citer,
  input  logic [IT_W-1:0]   cfg_biter,
  input  logic [NB_W-1:0]   cfg_nbytes,
  input  logic [1:0]        cfg_size,
  input  logic [1:0]        cfg_bwc,
  input  logic [1:0]        cfg_link_mode,
  input  logic [CH_W-1:0]   cfg_link_ch,
  input  logic              cfg_int_major,
  input  logic              cfg_int_half,
  input  logic              cfg_auto_stop,
  input  logic              cfg_cont_link,
  input  logic              acc_done,
  output logic              rd_req,
  output logic              wr_req,
  output logic              busy,
  output logic              link_out,
  output logic [CH_W-1:0]   link_ch_out,
  output logic              done,
  output logic              cfg_err,
  output logic              irq,
  output logic              req_en,
  output logic [IT_W-1:0]   citer_out,
  output logic [NB_W+IT_W-1:0] rem_bytes
);
  localparam int RB_W = NB_W + IT_W;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_STALL, S_FIN} st_t;

  st_t             st;
  logic [NB_W-1:0] cnt;
  logic [2:0]      scnt;
  logic            to_wr, to_fin, fresh;
  logic [IT_W-1:0] citer;

  wire [NB_W-1:0] sz        = NB_W'(1) << cfg_size;
  wire            sz_bad    = (cfg_size == 2'd3);
  wire            nb_bad    = (cfg_nbytes == '0) || ((cfg_nbytes & (sz - NB_W'(1))) != '0);
  wire            it_bad    = (citer == '0) || (fresh && (citer != cfg_biter));
  wire            bad       = sz_bad || nb_bad || it_bad;
  wire            go        = (hw_req && req_en) || sw_start || link_in;
  wire            has_stall = cfg_bwc[1];
  wire [2:0]      stall_ld  = cfg_bwc[0] ? 3'd7 : 3'd3;
  wire            last_acc  = (cnt == sz);
  wire [IT_W-1:0] citer_n   = citer - IT_W'(1);
  wire            exhaust   = (citer_n == '0);
  wire            self_cont = cfg_cont_link && (cfg_link_mode == 2'd1) &&
                              (cfg_link_ch == CH_W'(CH_ID));

  assign rd_req      = (st == S_RD);
  assign wr_req      = (st == S_WR);
  assign busy        = (st != S_IDLE);
  assign citer_out   = citer;
  assign link_ch_out = cfg_link_ch;
  assign rem_bytes   = RB_W'(citer) * RB_W'(cfg_nbytes);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      scnt     <= '0;
      to_wr    <= 1'b0;
      to_fin   <= 1'b0;
      fresh    <= 1'b1;
      citer    <= '0;
      done     <= 1'b0;
      cfg_err  <= 1'b0;
      irq      <= 1'b0;
      req_en   <= 1'b0;
      link_out <= 1'b0;
    end else begin
      link_out <= 1'b0;
      if (req_en_set) req_en <= 1'b1;
      if (cfg_load) begin
        citer   <= cfg_citer;
        done    <= 1'b0;
        irq     <= 1'b0;
        cfg_err <= 1'b0;
        fresh   <= 1'b1;
      end
      case (st)
        S_IDLE:
          if (go && !cfg_err && !cfg_load) begin
            if (bad) cfg_err <= 1'b1;
            else begin
              fresh <= 1'b0;
              cnt   <= cfg_nbytes;
              st    <= S_RD;
            end
          end
        S_RD:
          if (acc_done) begin
            if (has_stall) begin
              st    <= S_STALL;
              scnt  <= stall_ld;
              to_wr <= 1'b1;
            end else st <= S_WR;
          end
        S_WR:
          if (acc_done) begin
            cnt <= cnt - sz;
            if (has_stall) begin
              st     <= S_STALL;
              scnt   <= stall_ld;
              to_wr  <= 1'b0;
              to_fin <= last_acc;
            end else st <= last_acc ? S_FIN : S_RD;
          end
        S_STALL:
          if (scnt == '0) st <= to_wr ? S_WR : (to_fin ? S_FIN : S_RD);
          else scnt <= scnt - 3'd1;
        S_FIN: begin
          st <= S_IDLE;
          if (exhaust) begin
            citer <= cfg_biter;
            done  <= 1'b1;
            fresh <= 1'b1;
            if (cfg_int_major) irq <= 1'b1;
            if (cfg_auto_stop) req_en <= 1'b0;
            if (cfg_link_mode == 2'd2 || (cfg_link_mode == 2'd1 && !self_cont))
              link_out <= 1'b1;
          end else begin
            citer <= citer_n;
            if (cfg_int_half && citer_n == (cfg_biter >> 1)) irq <= 1'b1;
            if (cfg_link_mode == 2'd1) begin
              if (self_cont) begin
                cnt <= cfg_nbytes;
                st  <= S_RD;
              end else link_out <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dma_loop_seq_chk #(
  parameter int NB_W = 16,
  parameter int IT_W = 9,
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_done,
  input logic            rd_req,
  input logic            wr_req,
  input logic            busy,
  input logic            link_out,
  input logic            done,
  input logic            cfg_err,
  input logic            irq,
  input logic            req_en,
  input logic [IT_W-1:0] citer_out,
  input logic [IT_W-1:0] cfg_biter,
  input logic [1:0]      cfg_link_mode,
  input logic            cfg_int_major,
  input logic            cfg_int_half,
  input logic            cfg_auto_stop
);
  assert_rd_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !acc_done) |=> rd_req);
  assert_wr_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !acc_done) |=> wr_req);
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (citer_out == cfg_biter));
  assert_link_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    link_out |-> (!busy && cfg_link_mode != 2'd0));
  assert_irq_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (cfg_int_major || cfg_int_half));
  assert_autostop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_en) |-> (done && cfg_auto_stop));
  assert_err_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);
endmodule

bind dma_loop_seq dma_loop_seq_chk #(.NB_W(NB_W), .IT_W(IT_W), .CH_W(CH_W)) u_chk (.*);

// File: tb/sim_dma_loop_seq.sv
module sim_dma_loop_seq;
  localparam int NB_W = 16, IT_W = 9, CH_W = 4;

  logic clk = 0, rst_n = 0;
  logic hw_req = 0, req_en_set = 0, sw_start = 0, link_in = 0, cfg_load = 0;
  logic [IT_W-1:0] cfg_citer = 0, cfg_biter = 0;
  logic [NB_W-1:0] cfg_nbytes = 0;
  logic [1:0] cfg_size = 0, cfg_bwc = 0, cfg_link_mode = 0;
  logic [CH_W-1:0] cfg_link_ch = 0;
  logic cfg_int_major = 0, cfg_int_half = 0, cfg_auto_stop = 0, cfg_cont_link = 0;
  logic acc_done = 0;
  logic rd_req, wr_req, busy, link_out, done, cfg_err, irq, req_en;
  logic [CH_W-1:0] link_ch_out;
  logic [IT_W-1:0] citer_out;
  logic [NB_W+IT_W-1:0] rem_bytes;

  dma_loop_seq #(.NB_W(NB_W), .IT_W(IT_W), .CH_W(CH_W), .CH_ID(0)) u0 (.*);

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0, finished = 0;
  int nrd, nwr, ngap, nlink, badord, lastch, lat = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rd_req || wr_req) begin
      if (lat == 0) begin
        acc_done = 1;
        if (rd_req) nrd++;
        else begin
          if (nrd != nwr + 1) badord++;
          nwr++;
        end
        lat = $urandom % 3;
      end else begin
        acc_done = 0;
        lat--;
      end
    end else acc_done = 0;
    if (busy && !rd_req && !wr_req) ngap++;
    if (link_out) begin nlink++; lastch = link_ch_out; end
  endtask

  function automatic int stall_of(input int bwc);
    return bwc == 2 ? 4 : (bwc == 3 ? 8 : 0);
  endfunction

  task automatic clr();
    nrd = 0; nwr = 0; ngap = 0; nlink = 0; badord = 0; lastch = -1;
  endtask

  task automatic load();
    cfg_load = 1; tick(); cfg_load = 0; tick();
  endtask

  task automatic run(input int src);
    int guard = 0;
    clr();
    tick();
    if (src == 0) sw_start = 1; else link_in = 1;
    tick();
    sw_start = 0; link_in = 0;
    while (busy && guard < 5000) begin tick(); guard++; end
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    chk(!busy && !done && !irq && !cfg_err && !req_en && !rd_req && !wr_req && !link_out,
        "R12 reset state", {busy, done, irq, cfg_err, req_en}, 0);

    // random configurations, R1 R2 R3 R4 R5 R6 R11
    for (int t = 0; t < 8; t++) begin
      int sz, nb, bi, bwc, lm, nacc, ce;
      sz = $urandom % 3; nb = (($urandom % 6) + 1) << sz; bi = ($urandom % 4) + 2;
      bwc = $urandom % 4; lm = $urandom % 3;
      cfg_size = sz[1:0]; cfg_nbytes = nb[NB_W-1:0]; cfg_biter = bi[IT_W-1:0];
      cfg_citer = bi[IT_W-1:0]; cfg_bwc = bwc[1:0]; cfg_link_mode = lm[1:0];
      cfg_link_ch = 4'd5 + t[3:0]; cfg_int_major = 1; cfg_int_half = 0;
      load();
      chk(!done && !irq && citer_out == cfg_citer, "R12 load", citer_out, bi);
      nacc = nb >> sz;
      for (int i = 1; i <= bi; i++) begin
        run(i % 2);
        ce = (i == bi) ? bi : bi - i;
        chk(nrd == nacc && nwr == nacc, "R2 R1 access count", nrd + nwr, 2 * nacc);
        chk(badord == 0, "R1 read before write", badord, 0);
        chk(ngap == 2 * nacc * stall_of(bwc) + 1, "R5 stall cycles", ngap,
            2 * nacc * stall_of(bwc) + 1);
        chk(citer_out == ce, "R3 count", citer_out, ce);
        chk(done == (i == bi), "R3 done", done, i == bi);
        chk(nlink == ((lm == 1) ? 1 : (lm == 2 && i == bi) ? 1 : 0), "R4 link pulses", nlink,
            (lm == 1) ? 1 : (lm == 2 && i == bi) ? 1 : 0);
        if (nlink > 0) chk(lastch == 5 + t, "R4 link channel", lastch, 5 + t);
        chk(irq == (i == bi), "R6 major irq", irq, i == bi);
        chk(rem_bytes == ce * nb, "R11 remaining bytes", rem_bytes, ce * nb);
      end
    end

    // half-count interrupt R7
    cfg_size = 0; cfg_nbytes = 2; cfg_bwc = 0; cfg_link_mode = 0;
    cfg_biter = 6; cfg_citer = 6; cfg_int_major = 0; cfg_int_half = 1;
    load();
    for (int i = 1; i <= 4; i++) begin
      run(0);
      chk(irq == (i >= 3), "R7 half irq", irq, i >= 3);
    end

    // auto stop R8 and request enable R12
    cfg_int_half = 0; cfg_int_major = 0; cfg_biter = 2; cfg_citer = 2;
    cfg_auto_stop = 1; cfg_nbytes = 4; cfg_size = 1;
    load();
    req_en_set = 1; tick(); req_en_set = 0; tick();
    chk(req_en == 1, "R12 req_en set", req_en, 1);
    clr();
    hw_req = 1;
    repeat (300) tick();
    chk(req_en == 0, "R8 req_en cleared", req_en, 0);
    chk(nrd == 4 && nwr == 4, "R8 held request ignored after stop", nrd, 4);
    chk(!busy && done, "R8 idle and done", busy, 0);
    hw_req = 0; cfg_auto_stop = 0;

    // configuration errors R9
    cfg_nbytes = 0; load(); run(0);
    chk(cfg_err && nrd == 0, "R9 zero bytes", nrd, 0);
    load();
    chk(!cfg_err, "R12 error cleared", cfg_err, 0);
    cfg_nbytes = 6; cfg_size = 2; load(); run(0);
    chk(cfg_err && nrd == 0, "R9 misaligned bytes", nrd, 0);
    cfg_nbytes = 8; cfg_size = 3; load(); run(0);
    chk(cfg_err && nrd == 0, "R9 size code 3", nrd, 0);
    cfg_size = 1; cfg_citer = 3; cfg_biter = 4; load(); run(1);
    chk(cfg_err && nrd == 0, "R9 count mismatch", nrd, 0);
    cfg_citer = 4; run(0);
    chk(cfg_err && nrd == 0, "R9 sticky error blocks", nrd, 0);
    load(); run(0);
    chk(!cfg_err && nrd == 4 && citer_out == 3, "R9 valid after load", nrd, 4);

    // continuous self-link R10
    cfg_biter = 3; cfg_citer = 3; cfg_nbytes = 4; cfg_size = 1; cfg_bwc = 0;
    cfg_link_mode = 1; cfg_link_ch = 0; cfg_cont_link = 1;
    load(); run(0);
    chk(nrd == 6 && nwr == 6, "R10 whole major loop", nrd, 6);
    chk(done && nlink == 0 && ngap == 3, "R10 no link pulse", nlink, 0);
    cfg_cont_link = 0; load(); run(0);
    chk(nrd == 2 && nlink == 1 && lastch == 0, "R10 without continuous", nrd, 2);

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule